// File: doc/BRIEF.md
# Tabular Prime Implicant Generator

This block finds every prime implicant of a Boolean function of up to five variables. Software or a neighbouring engine drives two minterm masks on a start pulse: the on-set and the don't-care set, where bit k of each mask stands for minterm k. The engine then works through merge passes. Each pass joins pairs of cubes that have the same eliminated variables and whose ones counts differ by one, because they differ in exactly one specified variable. The joined cube has that variable eliminated. Both source cubes are flagged as absorbed.

Don't-care minterms join the starting terms, so they can widen implicants. A cube that is never absorbed is prime. Once the passes stop producing new cubes, the engine streams out the primes one per valid strobe and then pulses done. A prime built only from don't-care minterms is still streamed, and a later cover stage may discard it.

Each cube is reported as a value/mask pair. A set mask bit means the variable is eliminated, and the value bit in that position is then zero. Value bit NVAR-1 is the most significant variable.

Top module: `tabular_pi_gen`

## Requirements
- R1: After reset, busy, done and pi_valid are all low.
- R2: A start pulse while busy is low raises busy on the next cycle. Busy stays high until the run ends and is low in the cycle that done is high.
- R3: Every streamed cube is a prime implicant of the union of on-set and don't-care set, with pi_value & pi_mask equal to zero (mask bit set = variable eliminated).
- R4: Every prime implicant of that union is streamed during the run.
- R5: No cube is streamed more than once in a run, even when several merge pairs yield it.
- R6: Don't-care minterms take part in merging, and a prime covering only don't-care minterms is still streamed.
- R7: For the four-variable function with minterms 2,4,6,8,9,10,12,13,15 (most significant variable held as eliminated), the primes 1-0-, -010, 01-0 and 11-1 appear.
- R8: Done is a single-cycle pulse that comes after the last pi_valid of the run, and pi_valid is low while done is high.
- R9: An empty function streams no cube and still ends with done.
- R10: A function that is true on all minterms streams exactly one cube, with every mask bit set.
- R11: The masks are taken in the start cycle. Later changes to them and start pulses while busy have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; taken only while idle |
| on_set | input | 2**NVAR | Minterms where the function is 1 |
| dc_set | input | 2**NVAR | Minterms where the function is unspecified |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last cube |
| pi_valid | output | 1 | pi_value/pi_mask carry a prime implicant |
| pi_value | output | NVAR | Cube values of the specified variables |
| pi_mask | output | NVAR | Set bits mark eliminated variables |

## Verification
The hardest case to reach from the ports is one cube produced by several different merge pairs in the same pass. This happens only when the function has wide implicants. The full-true function and dense random masks produce many such coincidences. Each emitted cube is recorded in a bitmap, so a second copy is caught.

Pass termination must also be covered. Single-minterm and don't-care-only cases make the engine stop after one pass, while the full-true function drives it through all five. A re-pulsed start with altered masks partway through a run shows that the captured function is kept.

// File: rtl/qm_pkg.sv
package qm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MERGE = 2'd1,
    ST_EMIT  = 2'd2,
    ST_FIN   = 2'd3
  } qm_state_e;
endpackage

// File: rtl/qm_seq.sv
module qm_seq
  import qm_pkg::*;
#(
  parameter int NVAR = 5,
  localparam int IW = 2 * NVAR,
  localparam int PW = $clog2(NVAR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          merged_now,
  output qm_state_e     state,
  output logic [IW-1:0] idx,
  output logic [PW-1:0] pass_lvl,
  output logic          load,
  output logic          scan_en,
  output logic          emit_en,
  output logic          fin
);
  localparam logic [IW-1:0] LAST = {IW{1'b1}};
  localparam logic [PW-1:0] PMAX = PW'(NVAR);

  logic merged_q;
  logic any_merge;

  assign any_merge = merged_q | merged_now;
  assign load      = (state == ST_IDLE) && start;
  assign scan_en   = (state == ST_MERGE);
  assign emit_en   = (state == ST_EMIT);
  assign fin       = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      pass_lvl <= '0;
      merged_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_MERGE;
            idx      <= '0;
            pass_lvl <= PW'(1);
            merged_q <= 1'b0;
          end
        end
        ST_MERGE: begin
          if (idx == LAST) begin
            idx <= '0;
            if (any_merge && (pass_lvl < PMAX)) begin
              pass_lvl <= pass_lvl + PW'(1);
              merged_q <= 1'b0;
            end else begin
              state <= ST_EMIT;
            end
          end else begin
            idx      <= idx + IW'(1);
            merged_q <= any_merge;
          end
        end
        ST_EMIT: begin
          if (idx == LAST) state <= ST_FIN;
          else             idx   <= idx + IW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qm_cube_store.sv
module qm_cube_store #(
  parameter int NVAR = 5,
  localparam int IW = 2 * NVAR,
  localparam int NCUBE = 1 << IW,
  localparam int NMIN = 1 << NVAR,
  localparam int PW = $clog2(NVAR + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [NMIN-1:0] on_set,
  input  logic [NMIN-1:0] dc_set,
  input  logic            scan_en,
  input  logic [PW-1:0]   pass_lvl,
  input  logic [IW-1:0]   idx,
  output logic            merged_now,
  output logic            is_prime
);
  // cube index = {mask, value}; only entries with value & mask == 0 are ever set
  logic [NCUBE-1:0] present;
  logic [NCUBE-1:0] used;
  logic [NVAR-1:0]  cm, cv;
  logic [NVAR-1:0]  cand;
  logic [IW-1:0]    pidx [NVAR];
  logic [IW-1:0]    nidx [NVAR];
  logic             level_ok;

  assign cm       = idx[IW-1:NVAR];
  assign cv       = idx[NVAR-1:0];
  assign level_ok = ($countones(cm) + 1) == int'(pass_lvl);

  for (genvar g = 0; g < NVAR; g++) begin : g_bit
    localparam logic [NVAR-1:0] OH = NVAR'(1) << g;
    // partner sits one ones-group higher, same mask
    assign pidx[g] = {cm, cv | OH};
    assign nidx[g] = {cm | OH, cv};
    assign cand[g] = scan_en && level_ok && present[idx] &&
                     !cm[g] && !cv[g] && present[pidx[g]];
  end

  assign merged_now = |cand;
  assign is_prime   = present[idx] && !used[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      present <= '0;
      used    <= '0;
    end else if (load) begin
      present <= {{(NCUBE - NMIN){1'b0}}, on_set | dc_set};
      used    <= '0;
    end else begin
      for (int b = 0; b < NVAR; b++) begin
        if (cand[b]) begin
          present[nidx[b]] <= 1'b1;
          used[idx]        <= 1'b1;
          used[pidx[b]]    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qm_pi_out.sv
module qm_pi_out #(
  parameter int NVAR = 5,
  localparam int IW = 2 * NVAR
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            emit_en,
  input  logic            is_prime,
  input  logic [IW-1:0]   idx,
  input  logic            fin,
  output logic            pi_valid,
  output logic [NVAR-1:0] pi_value,
  output logic [NVAR-1:0] pi_mask,
  output logic            done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pi_valid <= 1'b0;
      pi_value <= '0;
      pi_mask  <= '0;
      done     <= 1'b0;
    end else begin
      pi_valid <= emit_en && is_prime;
      pi_value <= idx[NVAR-1:0];
      pi_mask  <= idx[IW-1:NVAR];
      done     <= fin;
    end
  end
endmodule

// File: rtl/tabular_pi_gen.sv
module tabular_pi_gen
  import qm_pkg::*;
#(
  parameter int NVAR = 5,
  localparam int NMIN = 1 << NVAR,
  localparam int IW = 2 * NVAR,
  localparam int PW = $clog2(NVAR + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NMIN-1:0] on_set,
  input  logic [NMIN-1:0] dc_set,
  output logic            busy,
  output logic            done,
  output logic            pi_valid,
  output logic [NVAR-1:0] pi_value,
  output logic [NVAR-1:0] pi_mask
);
  qm_state_e       state;
  logic [IW-1:0]   idx;
  logic [PW-1:0]   pass_lvl;
  logic            load, scan_en, emit_en, fin;
  logic            merged_now, is_prime;

  assign busy = (state != ST_IDLE);

  qm_seq #(.NVAR(NVAR)) u_seq (
    .clk(clk), .rst(rst), .start(start), .merged_now(merged_now),
    .state(state), .idx(idx), .pass_lvl(pass_lvl), .load(load),
    .scan_en(scan_en), .emit_en(emit_en), .fin(fin)
  );

  qm_cube_store #(.NVAR(NVAR)) u_store (
    .clk(clk), .rst(rst), .load(load), .on_set(on_set), .dc_set(dc_set),
    .scan_en(scan_en), .pass_lvl(pass_lvl), .idx(idx),
    .merged_now(merged_now), .is_prime(is_prime)
  );

  qm_pi_out #(.NVAR(NVAR)) u_out (
    .clk(clk), .rst(rst), .emit_en(emit_en), .is_prime(is_prime), .idx(idx),
    .fin(fin), .pi_valid(pi_valid), .pi_value(pi_value), .pi_mask(pi_mask),
    .done(done)
  );
endmodule

// File: rtl/qm_check.sv
module qm_check #(
  parameter int NVAR = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            pi_valid,
  input logic [NVAR-1:0] pi_value,
  input logic [NVAR-1:0] pi_mask
);
  AST_CUBE_WELLFORMED: assert property (@(posedge clk) disable iff (rst)
    pi_valid |-> ((pi_value & pi_mask) == '0)); // R3
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R2
  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    pi_valid |-> busy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    done |-> !pi_valid); // R8
endmodule

bind tabular_pi_gen qm_check #(.NVAR(NVAR)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .pi_valid(pi_valid), .pi_value(pi_value), .pi_mask(pi_mask)
);

// File: tb/tb_tabular_pi_gen.sv
module tb_tabular_pi_gen;
  localparam int NVAR = 5;
  localparam int NMIN = 1 << NVAR;
  localparam int NC = 1 << (2 * NVAR);
  localparam int WD = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NMIN-1:0] on_set = '0, dc_set = '0;
  logic busy, done, pi_valid;
  logic [NVAR-1:0] pi_value, pi_mask;

  int checks = 0, errors = 0;
  logic [NC-1:0] got, expd;
  int got_cnt, dup_cnt;

  always #10 clk = ~clk;

  tabular_pi_gen #(.NVAR(NVAR)) dut (
    .clk(clk), .rst(rst), .start(start), .on_set(on_set), .dc_set(dc_set),
    .busy(busy), .done(done), .pi_valid(pi_valid), .pi_value(pi_value),
    .pi_mask(pi_mask)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_imp(input logic [NMIN-1:0] f, input int m, input int v);
    for (int k = 0; k < NMIN; k++)
      if (((k & ~m) & (NMIN - 1)) == v && !f[k]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [NC-1:0] ref_primes(input logic [NMIN-1:0] f);
    logic [NC-1:0] r = '0;
    for (int m = 0; m < NMIN; m++)
      for (int v = 0; v < NMIN; v++)
        if ((v & m) == 0 && is_imp(f, m, v)) begin
          bit p = 1'b1;
          for (int b = 0; b < NVAR; b++)
            if (!m[b] && is_imp(f, m | (1 << b), v & ~(1 << b))) p = 1'b0;
          r[m * NMIN + v] = p;
        end
    return r;
  endfunction

  task automatic run(input logic [NMIN-1:0] on, input logic [NMIN-1:0] dc,
                     input bit disturb);
    int cyc = 0;
    bit late_valid = 1'b0;
    got = '0; got_cnt = 0; dup_cnt = 0;
    @(negedge clk); on_set = on; dc_set = dc; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    if (disturb) begin
      on_set = ~on; dc_set = '0;
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done && cyc < WD) begin
      if (pi_valid) begin
        int id = int'(pi_mask) * NMIN + int'(pi_value);
        if (got[id]) dup_cnt++;
        got[id] = 1'b1;
        got_cnt++;
      end
      @(negedge clk); cyc++;
    end
    chk(cyc < WD, "R2", "run reached done (watchdog)", cyc, WD);
    chk(!pi_valid, "R8", "pi_valid low with done", pi_valid, 0);
    chk(!busy, "R2", "busy low with done", busy, 0);
    @(negedge clk);
    if (pi_valid) late_valid = 1'b1;
    chk(!done && !late_valid, "R8", "done single pulse, no cube after", done, 0);
    expd = ref_primes(on | dc);
    chk((got & ~expd) == '0, "R3", "non-prime cubes streamed",
        $countones(got & ~expd), 0);
    chk((expd & ~got) == '0, "R4", "primes missing", $countones(expd & ~got), 0);
    chk(dup_cnt == 0, "R5", "duplicate cubes", dup_cnt, 0);
  endtask

  function automatic logic [NMIN-1:0] dup4(input logic [15:0] f4);
    return {f4, f4};
  endfunction

  initial begin
    logic [15:0] ex4;
    void'($urandom(32'd2441));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pi_valid, "R1", "outputs after reset",
        {busy, done, pi_valid}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R7: four-variable example, top variable eliminated
    ex4 = '0;
    foreach (ex4[i]) ex4[i] = (i inside {2, 4, 6, 8, 9, 10, 12, 13, 15});
    run(dup4(ex4), '0, 1'b0);
    chk(got[5'b10101 * NMIN + 5'b01000], "R7", "cube 1-0-", 0, 1);
    chk(got[5'b11000 * NMIN + 5'b00010], "R7", "cube -010", 0, 1);
    chk(got[5'b10010 * NMIN + 5'b00100], "R7", "cube 01-0", 0, 1);
    chk(got[5'b10010 * NMIN + 5'b01101], "R7", "cube 11-1", 0, 1);

    // R6: don't-care widens and dc-only prime still emitted
    run(32'h0000_0008, 32'h0000_0080, 1'b0);
    chk(got[5'b00100 * NMIN + 5'b00011], "R6", "dc-widened cube", 0, 1);
    run(32'h0000_0001, 32'h8000_0000, 1'b0);
    chk(got[31] && got_cnt == 2, "R6", "dc-only prime count", got_cnt, 2);

    // R9 empty, R10 full
    run('0, '0, 1'b0);
    chk(got_cnt == 0, "R9", "empty function cubes", got_cnt, 0);
    run('1, '0, 1'b0);
    chk(got_cnt == 1 && got[31 * NMIN], "R10", "full function single cube",
        got_cnt, 1);

    // R11: inputs changed and start re-pulsed during run
    run(dup4(ex4), 32'h0001_0000, 1'b1);
    chk(got_cnt == $countones(expd), "R11", "result of captured masks",
        got_cnt, $countones(expd));

    // random masks
    for (int t = 0; t < 10; t++) begin
      logic [NMIN-1:0] on = $urandom;
      logic [NMIN-1:0] dc = $urandom & $urandom & ~on;
      run(on, dc, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule